// File: doc/BRIEF.md
# Bit-Sliced ALU with Condition Flags

This block is a purely combinational arithmetic-logic unit assembled from identical one-bit slices. Each slice conditions its operand bits and computes a full-adder sum and carry. It then picks one of four results under a 2-bit operation code. The slices are linked by a ripple carry. The ALU takes two operands of `WIDTH` bits (default 3) and a 4-bit control word. It returns the selected result and four condition flags: carry, overflow, negative and zero.

Subtraction needs no separate path. One control bit inverts operand B and also supplies the carry into bit 0, so the adder forms A plus the two's complement of B. A second bit inverts operand A, which gives the complemented-operand forms such as NOR and NAND. The less-than operation takes the sign of the raw adder sum and routes it back into bit 0 of the result. Every higher bit of that result is 0.

Top module: `ripple_alu`

## Requirements
- R1: Control word layout: bit 3 inverts A, bit 2 inverts B and is also the carry into bit 0, and bits [1:0] select the operation: 00 AND, 01 OR, 10 adder sum, 11 less-than. Example: A=011, B=101, control 1100 gives result 000 and flags C=0, V=0, N=0, Z=1.
- R2: With select 00, the result is the bitwise AND of the conditioned operands.
- R3: With select 01, the result is the bitwise OR of the conditioned operands.
- R4: With select 10, the result is (conditioned A + conditioned B + bit 2) modulo 2^WIDTH.
- R5: With select 11, bit 0 of the result equals the most significant bit of the adder sum, and all other result bits are 0.
- R6: The C flag equals the carry out of the most significant slice, whatever the operation select.
- R7: The V flag equals the carry out of the top slice XOR the carry into the top slice. This is 1 exactly when the two's complement addition of the conditioned operands overflows.
- R8: The N flag equals the most significant bit of the selected result, not of the adder sum.
- R9: The Z flag is 1 exactly when every bit of the selected result is 0.
- R10: The `WIDTH` parameter widens the ALU, and all of the rules above hold at any width of 1 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctrl_i | input | 4 | Control word: invert-A, negate-B, operation select |
| result_o | output | WIDTH | Selected result |
| flag_c_o | output | 1 | Carry out of the top slice |
| flag_v_o | output | 1 | Signed overflow |
| flag_n_o | output | 1 | Sign bit of the selected result |
| flag_z_o | output | 1 | Selected result is all zeros |

## Verification
Whenever the inputs are known, the bound checker compares the ripple chain with plain vector arithmetic. It checks the sum, the carry out, and overflow derived from the operand and result signs. It also checks the shape of the less-than result, the AND and OR results, and the N and Z flags against the result bus. The bench sweeps every operand pair under all sixteen control words at the default width and at width 5, so it also covers the flag behaviour on non-arithmetic selects. The bench also checks the worked example of the control encoding. A correct width extension shows up only in the second sweep.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_SUM  = 2'b10,
        OP_LESS = 2'b11
    } op_sel_e;

    // Packed so that the msb is the invert-A bit and the low two bits are the select.
    typedef struct packed {
        logic    inv_a;
        logic    neg_b;
        op_sel_e op;
    } alu_ctrl_t;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } alu_flags_t;

    localparam int CTRL_BITS = $bits(alu_ctrl_t);

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import ripple_alu_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  alu_ctrl_t ctrl,
    input  logic      carry_in,
    input  logic      less_in,
    output logic      sum_bit,
    output logic      carry_out,
    output logic      res_bit
);
    logic a_c;
    logic b_c;
    logic half;

    assign a_c       = a_bit ^ ctrl.inv_a;
    assign b_c       = b_bit ^ ctrl.neg_b;
    assign half      = a_c ^ b_c;
    assign sum_bit   = half ^ carry_in;
    assign carry_out = (a_c & b_c) | (carry_in & half);

    always_comb begin
        unique case (ctrl.op)
            OP_AND:  res_bit = a_c & b_c;
            OP_OR:   res_bit = a_c | b_c;
            OP_SUM:  res_bit = sum_bit;
            OP_LESS: res_bit = less_in;
            default: res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import ripple_alu_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] result,
    input  logic             carry_top_in,
    input  logic             carry_top_out,
    output alu_flags_t       flags
);
    always_comb begin
        flags.c = carry_top_out;
        flags.v = carry_top_out ^ carry_top_in;
        flags.n = result[WIDTH-1];
        flags.z = ~|result;
    end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       ctrl_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_c_o,
    output logic             flag_v_o,
    output logic             flag_n_o,
    output logic             flag_z_o
);
    localparam int TOP = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] less;
    alu_flags_t       flags;

    assign ctrl     = alu_ctrl_t'(ctrl_i);
    assign carry[0] = ctrl.neg_b;

    // Sign of the raw sum goes back into bit 0; every other slice sees 0.
    always_comb begin
        less    = '0;
        less[0] = sum[TOP];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .a_bit     (a_i[i]),
            .b_bit     (b_i[i]),
            .ctrl      (ctrl),
            .carry_in  (carry[i]),
            .less_in   (less[i]),
            .sum_bit   (sum[i]),
            .carry_out (carry[i+1]),
            .res_bit   (result_o[i])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .result        (result_o),
        .carry_top_in  (carry[TOP]),
        .carry_top_out (carry[WIDTH]),
        .flags         (flags)
    );

    assign flag_c_o = flags.c;
    assign flag_v_o = flags.v;
    assign flag_n_o = flags.n;
    assign flag_z_o = flags.z;
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
    parameter int WIDTH = 3
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       ctrl_i,
    input logic [WIDTH-1:0] result_o,
    input logic             flag_c_o,
    input logic             flag_v_o,
    input logic             flag_n_o,
    input logic             flag_z_o
);
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;
    logic             v_ref;

    always_comb begin
        a_eff = ctrl_i[3] ? ~a_i : a_i;
        b_eff = ctrl_i[2] ? ~b_i : b_i;
        full  = {1'b0, a_eff} + {1'b0, b_eff} + {{WIDTH{1'b0}}, ctrl_i[2]};
        v_ref = (a_eff[WIDTH-1] == b_eff[WIDTH-1]) && (full[WIDTH-1] != a_eff[WIDTH-1]);
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, ctrl_i})) begin
            if (ctrl_i[1:0] == 2'b00)
                p_and_r2: assert (result_o == (a_eff & b_eff));
            if (ctrl_i[1:0] == 2'b01)
                p_or_r3: assert (result_o == (a_eff | b_eff));
            if (ctrl_i[1:0] == 2'b10)
                p_sum_r4: assert (result_o == full[WIDTH-1:0]);
            if (ctrl_i[1:0] == 2'b11)
                p_less_r5: assert (((result_o >> 1) == '0) && (result_o[0] == full[WIDTH-1]));
            p_carry_r6: assert (flag_c_o == full[WIDTH]);
            p_overflow_r7: assert (flag_v_o == v_ref);
            p_sign_r8: assert (flag_n_o == result_o[WIDTH-1]);
            p_zero_r9: assert (flag_z_o == (result_o == '0));
        end
    end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o),
    .flag_c_o (flag_c_o),
    .flag_v_o (flag_v_o),
    .flag_n_o (flag_n_o),
    .flag_z_o (flag_z_o)
);

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [2:0] a3, b3, r3;
    logic [3:0] c3;
    logic       fc3, fv3, fn3, fz3;
    logic [4:0] a5, b5, r5;
    logic [3:0] c5;
    logic       fc5, fv5, fn5, fz5;

    ripple_alu #(.WIDTH(3)) uut (
        .a_i(a3), .b_i(b3), .ctrl_i(c3), .result_o(r3),
        .flag_c_o(fc3), .flag_v_o(fv3), .flag_n_o(fn3), .flag_z_o(fz3)
    );

    ripple_alu #(.WIDTH(5)) uut_w5 (
        .a_i(a5), .b_i(b5), .ctrl_i(c5), .result_o(r5),
        .flag_c_o(fc5), .flag_v_o(fv5), .flag_n_o(fn5), .flag_z_o(fz5)
    );

    task automatic check(input string tag, input int w, input int a, input int b,
                         input int c, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s w=%0d a=%0d b=%0d ctrl=%b: got %0d expected %0d",
                     tag, w, a, b, c[3:0], got, exp);
        end
    endtask

    task automatic apply(input int w, input int a, input int b, input int c,
                         output int res, output int fc, output int fv,
                         output int fn, output int fz);
        @(negedge clk);
        if (w == 3) begin a3 = 3'(a); b3 = 3'(b); c3 = 4'(c); end
        else        begin a5 = 5'(a); b5 = 5'(b); c5 = 4'(c); end
        #1;
        if (w == 3) begin res = int'(r3); fc = int'(fc3); fv = int'(fv3); fn = int'(fn3); fz = int'(fz3); end
        else        begin res = int'(r5); fc = int'(fc5); fv = int'(fv5); fn = int'(fn5); fz = int'(fz5); end
    endtask

    task automatic sweep(input int w);
        int mask = (1 << w) - 1;
        int low  = (1 << (w - 1)) - 1;
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a <= mask; a++) begin
                for (int b = 0; b <= mask; b++) begin
                    int ae, be, cin, full, sum, ec, ecin, ev, er;
                    int res, fc, fv, fn, fz;
                    string rtag;
                    ae   = c[3] ? (~a & mask) : a;
                    be   = c[2] ? (~b & mask) : b;
                    cin  = c[2];
                    full = ae + be + cin;
                    sum  = full & mask;
                    ec   = (full >> w) & 1;
                    ecin = (((ae & low) + (be & low) + cin) >> (w - 1)) & 1;
                    ev   = ec ^ ecin;
                    case (c & 3)
                        0: begin er = ae & be; rtag = (w == 3) ? "R1/R2 AND" : "R10/R2 AND"; end
                        1: begin er = ae | be; rtag = (w == 3) ? "R1/R3 OR" : "R10/R3 OR"; end
                        2: begin er = sum;     rtag = (w == 3) ? "R1/R4 SUM" : "R10/R4 SUM"; end
                        default: begin er = (sum >> (w - 1)) & 1; rtag = (w == 3) ? "R1/R5 LESS" : "R10/R5 LESS"; end
                    endcase
                    apply(w, a, b, c, res, fc, fv, fn, fz);
                    check(rtag, w, a, b, c, res, er);
                    check("R6 carry", w, a, b, c, fc, ec);
                    check("R7 overflow", w, a, b, c, fv, ev);
                    check("R8 negative", w, a, b, c, fn, (er >> (w - 1)) & 1);
                    check("R9 zero", w, a, b, c, fz, (er == 0) ? 1 : 0);
                end
            end
        end
    endtask

    initial begin
        a3 = '0; b3 = '0; c3 = '0;
        a5 = '0; b5 = '0; c5 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        begin
            int res, fc, fv, fn, fz;
            // Initial state: zero operands, AND select.
            apply(3, 0, 0, 0, res, fc, fv, fn, fz);
            check("R9 initial result", 3, 0, 0, 0, res, 0);
            check("R9 initial Z", 3, 0, 0, 0, fz, 1);
            // Worked control-word example for R1: 011, 101, 1100.
            apply(3, 3, 5, 12, res, fc, fv, fn, fz);
            check("R1 example result", 3, 3, 5, 12, res, 0);
            check("R1 example C", 3, 3, 5, 12, fc, 0);
            check("R1 example V", 3, 3, 5, 12, fv, 0);
            check("R1 example N", 3, 3, 5, 12, fn, 0);
            check("R1 example Z", 3, 3, 5, 12, fz, 1);
            // Same operands, less-than select: raw sum 111 gives 001 (R5).
            apply(3, 3, 5, 15, res, fc, fv, fn, fz);
            check("R5 example result", 3, 3, 5, 15, res, 1);
            check("R8 example N", 3, 3, 5, 15, fn, 0);
        end
        sweep(3);
        sweep(5);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(5 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule